// File: doc/BRIEF.md
# Calendar Time Counter with Deferred Write Commit

This block keeps wall-clock time and calendar date in two packed words. One word holds hours, minutes and seconds. The other holds day, month, a six-bit year counted from 1970 (so the years 1970 to 2033 can be shown), and a leap-year flag. Both words advance once for every pulse on a one-second tick input. Seconds carry into minutes, minutes into hours, and hours into the day. The day then rolls into the month, and the month rolls into the year.

Software loads a new value through a single write port, which selects either the time word or the date word. The value is not applied at once. The write raises a busy flag for the selected word, and the written value waits in a holding slot until a fixed number of one-second ticks has passed. The hand-over into the slow time base is modelled by that tick delay. On the commit tick the held value replaces the counter contents, and the busy flag drops on the same edge. Software polls the busy flags and starts a new write only when both flags are clear. A write that arrives while either flag is set is discarded.

Top module: `cal_time_keeper`

## Requirements
- R1: After synchronous reset the time word is 0 (00:00:00), the date word is 0x0000_0101 (day 1, month 1, year offset 0, leap flag 0), and both busy flags are 0.
- R2: The time word carries seconds in bits 5:0, minutes in bits 13:8 and hours in bits 20:16. All other bits read 0.
- R3: The date word carries day in bits 4:0, month (1 to 12) in bits 11:8, the year offset from 1970 in bits 21:16 and the leap flag in bit 22. All other bits read 0.
- R4: On each tick the seconds go up by one. Seconds wrap from 59 to 0 and carry into minutes, minutes wrap from 59 to 0 and carry into hours, and hours wrap from 23 to 0 and carry one day into the date.
- R5: On a day carry the day wraps to 1 after the last day of its month. April, June, September and November have 30 days. February has 29 days when the leap flag is 1 and 28 days when it is 0. All other months have 31 days.
- R6: When the month wraps from 12 to 1, the year offset goes up by one, and the year offset wraps from 63 to 0. The leap flag is then recomputed as 1 exactly when (offset + 2) is a multiple of 4.
- R7: A write with wr_en=1 while both busy flags are 0 is accepted. wr_sel_time=1 targets the time word and sets busy_flags[1]. wr_sel_time=0 targets the date word and sets busy_flags[0]. The flag is set one clock after the write, and the visible words keep counting until the commit.
- R8: An accepted write commits on the COMMIT_TICKS-th tick after it (2 by default). On that clock edge the targeted word takes the written value, and its busy flag clears on the same edge.
- R9: A write made while any busy flag is set is ignored. It changes neither the busy flags nor the value that will be committed, and it never reaches either word.
- R10: On a commit tick the committed word does not advance. A day carry from the time word that falls on the tick that commits the date word is lost.
- R11: Without a tick neither word changes, whether or not a write is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse marking one elapsed second |
| wr_en | input | 1 | Write strobe |
| wr_sel_time | input | 1 | Write target: 1 selects the time word, 0 selects the date word |
| wr_data | input | 32 | Packed value to write, in the layout of the selected word |
| time_word | output | 32 | Current packed hours, minutes and seconds |
| date_word | output | 32 | Current packed day, month, year offset and leap flag |
| busy_flags | output | 2 | Bit 1 is the pending time write, bit 0 is the pending date write |

## Verification
The bench targets the day rollover for all three month lengths, February with and without the leap flag, the December-to-January year step with its leap recomputation, and the year offset wrapping from 63 to 0. A design that mis-sized a month, or ignored the flag, would show a day 29, 30 or 31 that should not exist, or skip one that should. It also checks the commit timing: the word must hold its running value for one tick and take the new value exactly on the second. An off-by-one delay, or a design that advanced the word on the commit tick, would show a value one second or one day off. Writes issued while a flag is set must vanish: a design that accepted them would change a busy flag or commit the wrong date. Finally, a time rollover that lands on the date commit tick must not bump the freshly loaded date.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int WORD_W  = 32;
    localparam int SEC_W   = 6;
    localparam int MIN_W   = 6;
    localparam int HOUR_W  = 5;
    localparam int DAY_W   = 5;
    localparam int MON_W   = 4;
    localparam int YEAR_W  = 6;
    localparam int SLOT_N  = 2;

    // index of each holding slot inside the busy vector
    typedef enum logic {
        SLOT_DATE = 1'b0,
        SLOT_TIME = 1'b1
    } slot_e;

    typedef struct packed {
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } hms_t;

    typedef struct packed {
        logic              leap;
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  mon;
        logic [DAY_W-1:0]  day;
    } ymd_t;

    function automatic logic [WORD_W-1:0] hms_pack(hms_t v);
        return {11'b0, v.hour, 2'b0, v.min, 2'b0, v.sec};
    endfunction

    function automatic hms_t hms_unpack(logic [WORD_W-1:0] w);
        hms_t v;
        v.sec  = w[5:0];
        v.min  = w[13:8];
        v.hour = w[20:16];
        return v;
    endfunction

    function automatic logic [WORD_W-1:0] ymd_pack(ymd_t v);
        return {9'b0, v.leap, v.year, 4'b0, v.mon, 3'b0, v.day};
    endfunction

    function automatic ymd_t ymd_unpack(logic [WORD_W-1:0] w);
        ymd_t v;
        v.day  = w[4:0];
        v.mon  = w[11:8];
        v.year = w[21:16];
        v.leap = w[22];
        return v;
    endfunction

    function automatic logic [DAY_W-1:0] month_len(logic [MON_W-1:0] mon, logic leap);
        case (mon)
            4'd2:                      return leap ? DAY_W'(29) : DAY_W'(28);
            4'd4, 4'd6, 4'd9, 4'd11:   return DAY_W'(30);
            default:                   return DAY_W'(31);
        endcase
    endfunction

    // offset 0 is 1970; a year is leap when (offset + 2) is a multiple of 4
    function automatic logic leap_of(logic [YEAR_W-1:0] year);
        logic [YEAR_W-1:0] shifted;
        shifted = year + YEAR_W'(2);
        return shifted[1:0] == 2'b00;
    endfunction

endpackage

// File: rtl/cal_commit_slot.sv
module cal_commit_slot #(
    parameter int W     = 32,
    parameter int TICKS = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         accept,
    input  logic [W-1:0] wdata,
    output logic         busy,
    output logic         commit,
    output logic [W-1:0] held
);
    localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] seen;

    assign commit = busy && tick && (seen == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            seen <= '0;
            held <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            seen <= '0;
            held <= wdata;
        end else if (busy && tick) begin
            if (seen == LAST) begin
                busy <= 1'b0;
            end else begin
                seen <= seen + CW'(1);
            end
        end
    end
endmodule

// File: rtl/cal_hms_counter.sv
module cal_hms_counter
    import cal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic load,
    input  hms_t load_val,
    output hms_t hms,
    output logic day_carry
);
    logic sec_end, min_end, hour_end;
    hms_t nxt;

    assign sec_end   = hms.sec  == SEC_W'(59);
    assign min_end   = hms.min  == MIN_W'(59);
    assign hour_end  = hms.hour == HOUR_W'(23);
    assign day_carry = tick && !load && sec_end && min_end && hour_end;

    always_comb begin
        nxt = hms;
        if (!sec_end) begin
            nxt.sec = hms.sec + SEC_W'(1);
        end else begin
            nxt.sec = '0;
            if (!min_end) begin
                nxt.min = hms.min + MIN_W'(1);
            end else begin
                nxt.min  = '0;
                nxt.hour = hour_end ? '0 : hms.hour + HOUR_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hms <= '0;
        end else if (load) begin
            hms <= load_val;
        end else if (tick) begin
            hms <= nxt;
        end
    end
endmodule

// File: rtl/cal_ymd_counter.sv
module cal_ymd_counter
    import cal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic load,
    input  ymd_t load_val,
    output ymd_t ymd
);
    localparam ymd_t RESET_DATE = '{leap: 1'b0, year: '0, mon: MON_W'(1), day: DAY_W'(1)};

    ymd_t nxt;
    logic [YEAR_W-1:0] year_up;

    assign year_up = ymd.year + YEAR_W'(1);

    always_comb begin
        nxt = ymd;
        if (ymd.day < month_len(ymd.mon, ymd.leap)) begin
            nxt.day = ymd.day + DAY_W'(1);
        end else begin
            nxt.day = DAY_W'(1);
            if (ymd.mon >= MON_W'(12)) begin
                nxt.mon  = MON_W'(1);
                nxt.year = year_up;
                nxt.leap = leap_of(year_up);
            end else begin
                nxt.mon = ymd.mon + MON_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ymd <= RESET_DATE;
        end else if (load) begin
            ymd <= load_val;
        end else if (adv) begin
            ymd <= nxt;
        end
    end
endmodule

// File: rtl/cal_time_keeper.sv
module cal_time_keeper
    import cal_pkg::*;
#(
    parameter int COMMIT_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic              wr_en,
    input  logic              wr_sel_time,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] time_word,
    output logic [WORD_W-1:0] date_word,
    output logic [SLOT_N-1:0] busy_flags
);
    logic [SLOT_N-1:0] accept;
    logic [SLOT_N-1:0] commit;
    logic [WORD_W-1:0] held [SLOT_N];
    logic              any_busy;
    hms_t              hms;
    ymd_t              ymd;
    logic              day_carry;

    assign any_busy = |busy_flags;

    for (genvar g = 0; g < SLOT_N; g++) begin : g_slot
        assign accept[g] = wr_en && !any_busy && (wr_sel_time == g[0]);

        cal_commit_slot #(
            .W     (WORD_W),
            .TICKS (COMMIT_TICKS)
        ) u_slot (
            .clk    (clk),
            .rst    (rst),
            .tick   (sec_tick),
            .accept (accept[g]),
            .wdata  (wr_data),
            .busy   (busy_flags[g]),
            .commit (commit[g]),
            .held   (held[g])
        );
    end

    cal_hms_counter u_hms (
        .clk       (clk),
        .rst       (rst),
        .tick      (sec_tick),
        .load      (commit[SLOT_TIME]),
        .load_val  (hms_unpack(held[SLOT_TIME])),
        .hms       (hms),
        .day_carry (day_carry)
    );

    cal_ymd_counter u_ymd (
        .clk      (clk),
        .rst      (rst),
        .adv      (day_carry),
        .load     (commit[SLOT_DATE]),
        .load_val (ymd_unpack(held[SLOT_DATE])),
        .ymd      (ymd)
    );

    assign time_word = hms_pack(hms);
    assign date_word = ymd_pack(ymd);
endmodule

// File: rtl/cal_time_keeper_chk.sv
module cal_time_keeper_chk (
    input logic        clk,
    input logic        rst,
    input logic        sec_tick,
    input logic        wr_en,
    input logic        wr_sel_time,
    input logic [31:0] time_word,
    input logic [31:0] date_word,
    input logic [1:0]  busy_flags
);
    // R7: an accepted time write raises only the time flag
    p_time_write_busy_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_sel_time && busy_flags == 2'b00 |=> busy_flags == 2'b10);

    // R7: an accepted date write raises only the date flag
    p_date_write_busy_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en && !wr_sel_time && busy_flags == 2'b00 |=> busy_flags == 2'b01);

    // R9: at most one write is ever pending
    p_one_pending_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(busy_flags));

    // R9: while pending, flags change only on a tick
    p_flags_hold_r9: assert property (@(posedge clk) disable iff (rst)
        busy_flags != 2'b00 && !sec_tick |=> $stable(busy_flags));

    // R11: no tick, no change in either word
    p_no_tick_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !sec_tick |=> $stable(time_word) && $stable(date_word));

    // R4: seconds step by one when nothing is pending
    p_sec_step_r4: assert property (@(posedge clk) disable iff (rst)
        sec_tick && busy_flags == 2'b00 && time_word[5:0] < 6'd59
        |=> time_word[5:0] == $past(time_word[5:0]) + 6'd1);

    // R4: seconds wrap to zero
    p_sec_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        sec_tick && busy_flags == 2'b00 && time_word[5:0] == 6'd59
        |=> time_word[5:0] == 6'd0);
endmodule

bind cal_time_keeper cal_time_keeper_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .sec_tick    (sec_tick),
    .wr_en       (wr_en),
    .wr_sel_time (wr_sel_time),
    .time_word   (time_word),
    .date_word   (date_word),
    .busy_flags  (busy_flags)
);

// File: tb/cal_time_keeper_tb.sv
`timescale 1ns/1ps
module cal_time_keeper_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sec_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel_time = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] time_word;
    logic [31:0] date_word;
    logic [1:0]  busy_flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    cal_time_keeper u_dut (
        .clk         (clk),
        .rst         (rst),
        .sec_tick    (sec_tick),
        .wr_en       (wr_en),
        .wr_sel_time (wr_sel_time),
        .wr_data     (wr_data),
        .time_word   (time_word),
        .date_word   (date_word),
        .busy_flags  (busy_flags)
    );

    typedef struct {
        logic [31:0] t;
        logic [31:0] d;
        logic [1:0]  b;
        bit          ct;
        bit          cd;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    function automatic logic [31:0] tw(int h, int m, int s);
        return {11'b0, 5'(h), 2'b0, 6'(m), 2'b0, 6'(s)};
    endfunction

    function automatic logic [31:0] dw(int y, int mo, int d, int lp);
        return {9'b0, 1'(lp), 6'(y), 4'b0, 4'(mo), 3'b0, 5'(d)};
    endfunction

    // monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            exp_t e;
            wait (sb_q.size() != 0);
            e = sb_q.pop_front();
            checks++;
            if (e.b !== busy_flags ||
                (e.ct && e.t !== time_word) ||
                (e.cd && e.d !== date_word)) begin
                fails++;
                $display("FAIL %s: time=%h date=%h busy=%b expected time=%h date=%h busy=%b",
                         e.tag, time_word, date_word, busy_flags, e.t, e.d, e.b);
            end
        end
    end

    task automatic expect_out(logic [31:0] t, logic [31:0] d, logic [1:0] b,
                              bit ct, bit cd, string tag);
        exp_t e;
        e.t = t; e.d = d; e.b = b; e.ct = ct; e.cd = cd; e.tag = tag;
        sb_q.push_back(e);
        wait (sb_q.size() == 0);
        #0;
    endtask

    task automatic tick_n(int n);
        repeat (n) begin
            sec_tick = 1'b1;
            @(negedge clk);
        end
        sec_tick = 1'b0;
    endtask

    task automatic wr(bit sel_time, logic [31:0] data);
        wr_en = 1'b1;
        wr_sel_time = sel_time;
        wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_time(logic [31:0] t);
        wr(1'b1, t);
        tick_n(2);
    endtask

    task automatic set_date(logic [31:0] d);
        wr(1'b0, d);
        tick_n(2);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        expect_out(32'h0, 32'h0000_0101, 2'b00, 1, 1, "R1 reset");

        // R4 R2 plain counting, R11 hold without tick
        tick_n(3);
        expect_out(tw(0,0,3), 32'h0000_0101, 2'b00, 1, 1, "R2 R4 three ticks");
        repeat (5) @(negedge clk);
        expect_out(tw(0,0,3), 32'h0000_0101, 2'b00, 1, 1, "R11 no tick");

        // R7 time write raises flag, counter keeps its value
        wr(1'b1, tw(23,59,58));
        expect_out(tw(0,0,3), 32'h0000_0101, 2'b10, 1, 1, "R7 time busy");
        repeat (3) @(negedge clk);
        expect_out(tw(0,0,3), 32'h0000_0101, 2'b10, 1, 1, "R11 pending no tick");
        // R9 write while busy is dropped
        wr(1'b0, dw(5,2,1,0));
        expect_out(tw(0,0,3), 32'h0000_0101, 2'b10, 1, 1, "R9 ignored write");
        tick_n(1);
        expect_out(tw(0,0,4), 32'h0000_0101, 2'b10, 1, 1, "R8 first tick");
        tick_n(1);
        expect_out(tw(23,59,58), 32'h0000_0101, 2'b00, 1, 1, "R8 R10 commit tick");
        tick_n(1);
        expect_out(tw(23,59,59), 32'h0000_0101, 2'b00, 1, 1, "R4 after commit");
        tick_n(1);
        expect_out(tw(0,0,0), 32'h0000_0102, 2'b00, 1, 1, "R4 R3 day carry");

        // R4 minute and hour carries
        set_time(tw(0,0,59));
        tick_n(1);
        expect_out(tw(0,1,0), 0, 2'b00, 1, 0, "R4 minute carry");
        set_time(tw(4,59,59));
        tick_n(1);
        expect_out(tw(5,0,0), 0, 2'b00, 1, 0, "R4 hour carry");

        // R7 date flag
        wr(1'b0, dw(2,2,28,1));
        expect_out(0, 32'h0000_0102, 2'b01, 0, 1, "R7 date busy");
        tick_n(2);
        expect_out(0, dw(2,2,28,1), 2'b00, 0, 1, "R8 R3 date commit");

        // R5 leap February
        set_time(tw(23,59,59));
        tick_n(1);
        expect_out(tw(0,0,0), dw(2,2,29,1), 2'b00, 1, 1, "R5 leap feb 29");
        set_time(tw(23,59,59));
        tick_n(1);
        expect_out(tw(0,0,0), dw(2,3,1,1), 2'b00, 1, 1, "R5 leap feb end");

        // R5 common February
        set_date(dw(1,2,28,0));
        set_time(tw(23,59,59));
        tick_n(1);
        expect_out(0, dw(1,3,1,0), 2'b00, 0, 1, "R5 common feb end");

        // R5 thirty-day month
        set_date(dw(10,4,30,0));
        set_time(tw(23,59,59));
        tick_n(1);
        expect_out(0, dw(10,5,1,0), 2'b00, 0, 1, "R5 april end");

        // R5 thirty-one-day month
        set_date(dw(10,5,30,0));
        set_time(tw(23,59,59));
        tick_n(1);
        expect_out(0, dw(10,5,31,0), 2'b00, 0, 1, "R5 may 31");

        // R6 year step, leap recomputed
        set_date(dw(3,12,31,0));
        set_time(tw(23,59,59));
        tick_n(1);
        expect_out(0, dw(4,1,1,0), 2'b00, 0, 1, "R6 year to non-leap");
        set_date(dw(5,12,31,0));
        set_time(tw(23,59,59));
        tick_n(1);
        expect_out(0, dw(6,1,1,1), 2'b00, 0, 1, "R6 year to leap");

        // R6 year offset wrap
        set_date(dw(63,12,31,0));
        set_time(tw(23,59,59));
        tick_n(1);
        expect_out(tw(0,0,0), dw(0,1,1,0), 2'b00, 1, 1, "R6 year wrap");

        // R10 day carry lost on date commit tick
        set_time(tw(23,59,58));
        wr(1'b0, dw(7,6,15,0));
        tick_n(1);
        expect_out(tw(23,59,59), dw(0,1,1,0), 2'b01, 1, 1, "R10 before commit");
        tick_n(1);
        expect_out(tw(0,0,0), dw(7,6,15,0), 2'b00, 1, 1, "R10 carry dropped");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule